// File: doc/BRIEF.md
# Keyboard Port Interrupt and Power Control

This block sits beside the core of a keyboard-scanning microcontroller. It keeps an 8-bit power control register and combines the active-low scan-input rows into a single "key pressed" request. One register bit steers that request onto either external interrupt line. The pin of the line it takes over is disconnected. The pin of the other line stays connected and serves as the keyboard clock.

A second register bit turns on enhanced pullups for the keyboard data pin and for whichever interrupt pin is acting as clock. For each quasi-bidirectional port bit, the block produces three pullup enables and one pulldown enable. One of the pullups is a short strong pulse that follows each 0-to-1 change of the port latch.

The block also controls idle and power-down. Idle stops only the core clock. Power-down stops the oscillator. An enabled, level-sensitive external interrupt restarts the oscillator through a purely combinational path while the line is low. The exit completes once the synchronised line has gone high again.

Top module: `kbd_pwr_ctl`

## Requirements
- R1: After reset, `pcon_q` reads 8'h00. Both clock enables and `osc_en` are high, and no strong pulse is active.
- R2: A write with `pcon_we` loads bits 7,6,4,3,2,1,0 of `pcon_wdata` into the register. Bit 5 always reads 0. Field order: bit7 pullup boost, bit6 scan route, bit4 power-off flag, bits3:2 general flags, bit1 power-down, bit0 idle.
- R3: A `por_pulse` sets bit 4 at the next edge, overriding a same-cycle write. A later write can clear it.
- R4: The scan request is active when any `ksi_n` bit is 0. With bit6=0 the request drives `int0_n` low and `int0_pin_n` is ignored, while `int1_n` follows `int1_pin_n`. With bit6=1 the roles of the two lines are swapped.
- R5: With bit7=0, no enhanced pullup is enabled. With bit7=1, `data_pu_enh` is high. `clk1_pu_enh` is high when bit6=0, and `clk0_pu_enh` is high when bit6=1.
- R6: When `port_latch[i]` is seen at 1 at an edge after being 0 at the previous edge, `strong_pu[i]` is high for exactly STRONG_CYC cycles. The pulse is cut short if the latch returns to 0.
- R7: `keeper_pu[i]` is high while `port_pin[i]` reads 1 or the strong pulse is on. `faint_pu[i]` is high and `pull_dn[i]` is low exactly while the latch holds 1.
- R8: With bit0 set and bit1 clear, `cpu_clk_en` is low and `per_clk_en` stays high. An `irq_event` clears bits 1 and 0 at the next edge, overriding a same-cycle write.
- R9: With bit1 set, both clock enables are low, whatever the value of bit0. `osc_en` is low unless a wake is in progress.
- R10: In power-down, `osc_en` rises in the same cycle as an enabled level-mode interrupt line goes low. The level is synchronised over two edges. The cycle after the synchronised level is seen high marks the wake as started. The first edge at which the synchronised level is seen low again, after that, clears bit 1.
- R11: A line set to edge mode, disabled individually, or masked by `glb_en` does not raise `osc_en` and does not end power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pcon_we | input | 1 | Register write strobe |
| pcon_wdata | input | 8 | Register write data |
| por_pulse | input | 1 | Power-on indication, sets the power-off flag |
| irq_event | input | 1 | Interrupt accepted by the core |
| glb_en | input | 1 | Global interrupt enable |
| ext0_en | input | 1 | Line 0 interrupt enable |
| ext1_en | input | 1 | Line 1 interrupt enable |
| ext0_edge | input | 1 | Line 0 edge mode (0 = level) |
| ext1_edge | input | 1 | Line 1 edge mode (0 = level) |
| ksi_n | input | SCAN_W | Active-low scan inputs |
| int0_pin_n | input | 1 | Line 0 pin |
| int1_pin_n | input | 1 | Line 1 pin |
| port_latch | input | PORT_W | Port output latch bits |
| port_pin | input | PORT_W | Port pin read-back |
| pcon_q | output | 8 | Register read value |
| int0_n | output | 1 | Routed interrupt line 0 |
| int1_n | output | 1 | Routed interrupt line 1 |
| data_pu_enh | output | 1 | Enhanced pullup, data pin |
| clk0_pu_enh | output | 1 | Enhanced pullup, line 0 pin |
| clk1_pu_enh | output | 1 | Enhanced pullup, line 1 pin |
| strong_pu | output | PORT_W | Strong transition pullups |
| keeper_pu | output | PORT_W | Weak keeper pullups |
| faint_pu | output | PORT_W | Very weak pullups |
| pull_dn | output | PORT_W | Pulldown enables |
| osc_en | output | 1 | Oscillator run enable |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |

## Verification
The bench uses the default widths: eight scan inputs, eight port bits, and a two-cycle strong pulse. At these widths every single-row key press can be reached, including the highest row. Every port bit can be toggled on its own. Back-to-back latch toggles can land both inside and just after a pulse, which covers both its truncation and its full length. The random phase mixes register writes with power-down entries. This lets wake attempts meet edge mode, masks and interrupt acceptance in the same cycle.

// File: rtl/kbd_pwr_ctl.sv
module kbd_pwr_ctl #(
  parameter int SCAN_W     = 8,
  parameter int PORT_W     = 8,
  parameter int STRONG_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pcon_we,
  input  logic [7:0]        pcon_wdata,
  input  logic              por_pulse,
  input  logic              irq_event,
  input  logic              glb_en,
  input  logic              ext0_en,
  input  logic              ext1_en,
  input  logic              ext0_edge,
  input  logic              ext1_edge,
  input  logic [SCAN_W-1:0] ksi_n,
  input  logic              int0_pin_n,
  input  logic              int1_pin_n,
  input  logic [PORT_W-1:0] port_latch,
  input  logic [PORT_W-1:0] port_pin,
  output logic [7:0]        pcon_q,
  output logic              int0_n,
  output logic              int1_n,
  output logic              data_pu_enh,
  output logic              clk0_pu_enh,
  output logic              clk1_pu_enh,
  output logic [PORT_W-1:0] strong_pu,
  output logic [PORT_W-1:0] keeper_pu,
  output logic [PORT_W-1:0] faint_pu,
  output logic [PORT_W-1:0] pull_dn,
  output logic              osc_en,
  output logic              cpu_clk_en,
  output logic              per_clk_en
);
  localparam int CW = $clog2(STRONG_CYC + 1);

  logic       boost, route, pof, pd, idl;
  logic [1:0] gflag;
  logic       wake_lvl, sync1, sync2, waking, wake_done;
  logic       key_req;
  logic       rsvd_unused;

  assign rsvd_unused = pcon_wdata[5];

  assign key_req = ~&ksi_n;
  assign int0_n  = route ? int0_pin_n : ~key_req;
  assign int1_n  = route ? ~key_req   : int1_pin_n;

  assign data_pu_enh = boost;
  assign clk0_pu_enh = boost & route;
  assign clk1_pu_enh = boost & ~route;

  assign wake_lvl  = glb_en & ((ext0_en & ~ext0_edge & ~int0_n) |
                               (ext1_en & ~ext1_edge & ~int1_n));
  assign wake_done = waking & ~sync2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boost <= 1'b0; route <= 1'b0; pof <= 1'b0;
      gflag <= 2'b00; pd <= 1'b0; idl <= 1'b0;
    end else begin
      if (pcon_we) begin
        boost <= pcon_wdata[7];
        route <= pcon_wdata[6];
        pof   <= pcon_wdata[4];
        gflag <= pcon_wdata[3:2];
        pd    <= pcon_wdata[1];
        idl   <= pcon_wdata[0];
      end
      if (por_pulse) pof <= 1'b1;
      if (irq_event) begin
        pd  <= 1'b0;
        idl <= 1'b0;
      end
      if (wake_done) pd <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= 1'b0;
      sync2  <= 1'b0;
      waking <= 1'b0;
    end else begin
      sync1  <= wake_lvl;
      sync2  <= sync1;
      waking <= pd & ~wake_done & (waking | sync2);
    end
  end

  assign pcon_q     = {boost, route, 1'b0, pof, gflag, pd, idl};
  assign osc_en     = ~pd | wake_lvl | sync1 | sync2 | waking;
  assign cpu_clk_en = ~pd & ~idl;
  assign per_clk_en = ~pd;

  logic [PORT_W-1:0] latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= port_latch;
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_bit
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt <= '0;
      else if (port_latch[i] & ~latch_q[i]) cnt <= CW'(STRONG_CYC);
      else if (!port_latch[i])            cnt <= '0;
      else if (cnt != '0)                 cnt <= cnt - 1'b1;
    end
    assign strong_pu[i] = (cnt != '0);
    assign keeper_pu[i] = port_pin[i] | strong_pu[i];
    assign faint_pu[i]  = port_latch[i];
    assign pull_dn[i]   = ~port_latch[i];
  end

  // R3
  por_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_pulse |=> pcon_q[4]);

  // R8
  irq_clears_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_event |=> (pcon_q[1:0] == 2'b00));

  // R6
  strong_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strong_pu[0]) |-> $past(port_latch[0]));

  // R9
  pd_gates_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcon_q[1] |-> (!cpu_clk_en && !per_clk_en));

  // R10
  pd_exit_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pcon_q[1]) && !$past(irq_event) && !$past(pcon_we)) |-> $past(osc_en));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pcon_we) |-> (pcon_q[5] == 1'b0));
endmodule

// File: tb/tb_kbd_pwr_ctl.sv
module tb_kbd_pwr_ctl;
  localparam int SW = 8, PW = 8, SC = 2;

  logic clk = 0, rst_n = 0;
  logic pcon_we = 0, por_pulse = 0, irq_event = 0;
  logic [7:0] pcon_wdata = 0;
  logic glb_en = 0, ext0_en = 0, ext1_en = 0, ext0_edge = 0, ext1_edge = 0;
  logic [SW-1:0] ksi_n = '1;
  logic int0_pin_n = 1, int1_pin_n = 1;
  logic [PW-1:0] port_latch = 0, port_pin = 0;
  logic [7:0] pcon_q;
  logic int0_n, int1_n, data_pu_enh, clk0_pu_enh, clk1_pu_enh;
  logic [PW-1:0] strong_pu, keeper_pu, faint_pu, pull_dn;
  logic osc_en, cpu_clk_en, per_clk_en;

  kbd_pwr_ctl #(.SCAN_W(SW), .PORT_W(PW), .STRONG_CYC(SC)) dut (.*);

  always #5 clk = ~clk;

  int vectors = 0, miscompares = 0;

  // reference state
  bit m_boost, m_route, m_pof, m_pd, m_idl;
  bit [1:0] m_gf;
  bit m_s1, m_s2, m_wk;
  int m_cnt[PW];
  bit [PW-1:0] m_lq;

  function automatic bit key_down();
    for (int i = 0; i < SW; i++) if (ksi_n[i] == 0) return 1;
    return 0;
  endfunction
  function automatic bit m_int0(); return m_route ? int0_pin_n : !key_down(); endfunction
  function automatic bit m_int1(); return m_route ? !key_down() : int1_pin_n; endfunction
  function automatic bit m_wake();
    bit a, b;
    a = ext0_en && !ext0_edge && !m_int0();
    b = ext1_en && !ext1_edge && !m_int1();
    return glb_en && (a || b);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_boost, m_route, m_pof, m_pd, m_idl} = 0; m_gf = 0;
      m_s1 = 0; m_s2 = 0; m_wk = 0; m_lq = 0;
      for (int i = 0; i < PW; i++) m_cnt[i] = 0;
    end else begin
      bit done, nwk, w;
      done = m_wk && !m_s2;
      w = m_wake();
      nwk = m_pd && !done && (m_wk || m_s2);
      if (pcon_we) begin
        m_boost = pcon_wdata[7]; m_route = pcon_wdata[6]; m_pof = pcon_wdata[4];
        m_gf = pcon_wdata[3:2]; m_pd = pcon_wdata[1]; m_idl = pcon_wdata[0];
      end
      if (por_pulse) m_pof = 1;
      if (irq_event) begin m_pd = 0; m_idl = 0; end
      if (done) m_pd = 0;
      m_s2 = m_s1; m_s1 = w; m_wk = nwk;
      for (int i = 0; i < PW; i++) begin
        if (port_latch[i] && !m_lq[i]) m_cnt[i] = SC;
        else if (!port_latch[i]) m_cnt[i] = 0;
        else if (m_cnt[i] > 0) m_cnt[i]--;
      end
      m_lq = port_latch;
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s t=%0t got=%h exp=%h", tag, $time, got, exp);
    end
  endtask

  task automatic compare_all();
    bit [PW-1:0] es, ek;
    bit pdv;
    for (int i = 0; i < PW; i++) begin
      es[i] = m_cnt[i] > 0;
      ek[i] = port_pin[i] || es[i];
    end
    pdv = m_pd;
    chk("R2 pcon_q", pcon_q, {m_boost, m_route, 1'b0, m_pof, m_gf, m_pd, m_idl});
    chk("R4 int0_n", int0_n, m_int0());
    chk("R4 int1_n", int1_n, m_int1());
    chk("R5 pullup boost", {data_pu_enh, clk0_pu_enh, clk1_pu_enh},
        {m_boost, m_boost && m_route, m_boost && !m_route});
    chk("R6 strong_pu", strong_pu, es);
    chk("R7 keeper_pu", keeper_pu, ek);
    chk("R7 faint/pulldown", {faint_pu, pull_dn}, {port_latch, ~port_latch});
    chk("R8 R9 clock enables", {cpu_clk_en, per_clk_en}, {!pdv && !m_idl, !pdv});
    chk("R10 R11 osc_en", osc_en, !pdv || m_wake() || m_s1 || m_s2 || m_wk);
  endtask

  task automatic step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(logic [7:0] d);
    pcon_we = 1; pcon_wdata = d; step(); pcon_we = 0;
  endtask

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) step();
    // R1 reset state
    chk("R1 reset pcon", pcon_q, 8'h00);
    chk("R1 reset clocks", {osc_en, cpu_clk_en, per_clk_en, |strong_pu}, 4'b1110);
    rst_n = 1; step();
    // R2 write, reserved bit dropped
    wr(8'hFC); step();
    chk("R2 readback FC", pcon_q, 8'hDC);
    wr(8'h00);
    // R3 power-off flag
    por_pulse = 1; step(); por_pulse = 0; step();
    chk("R3 pof set", pcon_q[4], 1'b1);
    pcon_we = 1; pcon_wdata = 8'h00; por_pulse = 1; step(); pcon_we = 0; por_pulse = 0; step();
    chk("R3 por beats write", pcon_q[4], 1'b1);
    wr(8'h00); step();
    chk("R3 software clear", pcon_q[4], 1'b0);
    // R4 routing
    ksi_n = 8'h7F; int0_pin_n = 1; step();
    chk("R4 route0 key", int0_n, 1'b0);
    int1_pin_n = 0; ksi_n = 8'hFF; int0_pin_n = 0; step();
    chk("R4 route0 pin ignored", int0_n, 1'b1);
    chk("R4 route0 int1 pin", int1_n, 1'b0);
    int1_pin_n = 1; int0_pin_n = 1;
    wr(8'h40); ksi_n = 8'hFE; step();
    chk("R4 route1 key", {int0_n, int1_n}, 2'b10);
    ksi_n = 8'hFF;
    // R5 pullups
    wr(8'hC0); step(); chk("R5 boost route1", {data_pu_enh, clk0_pu_enh, clk1_pu_enh}, 3'b110);
    wr(8'h80); step(); chk("R5 boost route0", {data_pu_enh, clk0_pu_enh, clk1_pu_enh}, 3'b101);
    wr(8'h00);
    // R6 R7 port pullups
    port_latch = 8'h01; step(); chk("R6 pulse on", strong_pu[0], 1'b1);
    step(); chk("R6 pulse second", strong_pu[0], 1'b1);
    step(); chk("R6 pulse ended", strong_pu[0], 1'b0);
    port_pin = 8'h01; step(); chk("R7 keeper by pin", keeper_pu[0], 1'b1);
    port_latch = 8'h81; step(); port_latch = 8'h01; step();
    chk("R6 truncated", strong_pu[7], 1'b0);
    port_latch = 0; port_pin = 0; step();
    // R8 idle
    wr(8'h01); step(); chk("R8 idle gate", {cpu_clk_en, per_clk_en}, 2'b01);
    irq_event = 1; step(); irq_event = 0; step(); chk("R8 idle cleared", pcon_q[0], 1'b0);
    // R9 precedence, R11 no wake in edge mode
    glb_en = 1; ext0_en = 1; ext0_edge = 1;
    wr(8'h43); step(); int0_pin_n = 0; repeat (4) step();
    chk("R9 both set", {cpu_clk_en, per_clk_en}, 2'b00);
    chk("R11 edge no wake", {osc_en, pcon_q[1]}, 2'b01);
    int0_pin_n = 1; repeat (4) step();
    chk("R11 still down", pcon_q[1], 1'b1);
    // R10 level wake through routed scan input on line 1
    ext1_en = 1; ext1_edge = 0; ksi_n = 8'hEF; step();
    chk("R10 osc restart", osc_en, 1'b1);
    repeat (3) step(); ksi_n = 8'hFF; repeat (6) step();
    chk("R10 pd exit", pcon_q[1], 1'b0);
    // random phase
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      compare_all();
      pcon_we = ($urandom % 12) == 0;
      pcon_wdata = $urandom;
      por_pulse = ($urandom % 40) == 0;
      irq_event = ($urandom % 30) == 0;
      glb_en = $urandom; ext0_en = $urandom; ext1_en = $urandom;
      ext0_edge = ($urandom % 3) == 0; ext1_edge = ($urandom % 3) == 0;
      ksi_n = (($urandom % 3) == 0) ? ~(8'h1 << ($urandom % 8)) : 8'hFF;
      int0_pin_n = ($urandom % 4) != 0; int1_pin_n = ($urandom % 4) != 0;
      port_latch = $urandom; port_pin = $urandom;
    end
    step();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule